// File: doc/BRIEF.md
# Serial Slave Address Match Unit

This unit sits beside the byte-wide shift register of a simple clocked serial bus controller that acts as a slave. The host programs an 8-bit own-address register with the number this device answers to. When the bus logic has received an address byte, it pulses a strobe and presents the byte. The unit compares that byte with the own address in the same cycle. On the next clock edge it updates a coincidence flag and a bus-release flag, and it can issue an interrupt.

A wake-up qualifier bit in the mode register decides which received bytes interrupt the host. With the qualifier set, only a matching address interrupts, so a sleeping device is woken only when it is addressed. With the qualifier clear, every received byte interrupts. Each interrupt is a one-cycle pulse and also sets a sticky pending bit that the host clears by writing 1 to it.

When the serial-enable bit is clear, the unit is halted. Halt is the reset state. In halt the shift register does not shift and the strobes are ignored. The host can still write and read the shift register as a plain byte register.

Top module: `slv_addr_match`

## Requirements
- R1: After reset all four registers read 0x00, the unit is halted, and `coin_o`, `rel_o`, `irq_o` and `irq_pend_o` are low.
- R2: While enabled, an address strobe whose byte equals the own address sets the coincidence flag on the next edge. A non-equal address byte clears it. The flag reads back as mode register bit 6.
- R3: A non-equal address byte while enabled clears the bus-release flag (status bit 1) on the next edge. `bus_rel_i` sets that flag. When both happen in the same cycle, the set wins.
- R4: With the wake-up bit (mode bit 5) at 1, `irq_o` pulses only after a matching address byte. It stays low after a non-matching address byte or a data byte.
- R5: With the wake-up bit at 0 and the unit enabled, `irq_o` pulses one cycle after every received byte. This covers an address strobe, matching or not, and a data strobe.
- R6: While halted (mode bit 7 = 0), `shift_i` and the byte strobes have no effect. The shift register (select 2) is written and read back as a plain byte.
- R7: While enabled, each `shift_i` moves the shift register one place toward bit 7 and loads `sin_i` into bit 0. `sout_o` shows bit 7. A host write to select 2 in the same cycle takes priority over the shift.
- R8: A full write to the mode register (select 0) sets bits 7, 5 and 4..0. Writing 0 to bit 6 clears the coincidence flag; writing 1 to it leaves the flag unchanged. A single-bit write (`reg_bit_i`) to select 0 changes only bit 7. A single-bit write to any other select has no effect.
- R9: Each `irq_o` pulse lasts one cycle and sets the pending bit (status bit 0, `irq_pend_o`). Writing 1 to status bit 0 clears the pending bit. A new interrupt in the same cycle wins over the clear.
- R10: The own-address register (select 1) holds and reads back any byte the host writes.
- R11: A matching address in the same cycle as a host write of 0 to mode bit 6 leaves the coincidence flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Host register write strobe |
| reg_bit_i | input | 1 | Qualifies the write as a single serial-enable bit write |
| reg_sel_i | input | 2 | Register select: 0 mode, 1 own address, 2 shift, 3 status |
| reg_wdata_i | input | 8 | Host write data |
| reg_rdata_o | output | 8 | Contents of the selected register |
| addr_vld_i | input | 1 | Address byte received strobe |
| addr_byte_i | input | 8 | Received address byte |
| data_vld_i | input | 1 | Data byte received strobe |
| bus_rel_i | input | 1 | Bus release detected, sets the release flag |
| shift_i | input | 1 | Shift clock enable |
| sin_i | input | 1 | Serial input bit |
| sout_o | output | 1 | Serial output, shift register bit 7 |
| coin_o | output | 1 | Address coincidence flag |
| rel_o | output | 1 | Bus-release flag |
| irq_o | output | 1 | One-cycle interrupt pulse |
| irq_pend_o | output | 1 | Sticky interrupt pending bit |

## Verification
Two events can land on the coincidence flag in one cycle: a matching address strobe and a host mode write that clears bit 6. The bench drives both in one step, and the flag must read 1 afterwards. The pending bit and the release flag have the same kind of race, each between a hardware set and a clear. The pending bit races an interrupt against a status write of 1. The release flag races `bus_rel_i` against a non-matching address. The bench provokes both races directly. It also mixes them in a random phase, where a behavioural model decides the winner each cycle and every output is compared on each clock.

// File: rtl/sam_pkg.sv
`timescale 1ns/1ps
package sam_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SEL_W  = 2;

  localparam logic [SEL_W-1:0] SEL_MODE  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_OWN   = 2'd1;
  localparam logic [SEL_W-1:0] SEL_SHIFT = 2'd2;
  localparam logic [SEL_W-1:0] SEL_STAT  = 2'd3;

  localparam int unsigned STAT_PEND_B = 0;
  localparam int unsigned STAT_REL_B  = 1;

  typedef struct packed {
    logic hit;
    logic miss;
    logic fire;
  } sam_ev_t;
endpackage

// File: rtl/sam_regs.sv
`timescale 1ns/1ps
module sam_regs
  import sam_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             bit_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             en_o,
  output logic             wake_o,
  output logic [DW-4:0]    aux_o,
  output logic [DW-1:0]    own_o,
  output logic             coin_clr_o,
  output logic             pend_clr_o,
  output logic             sr_wr_o
);
  localparam int unsigned EN_B   = DW - 1;
  localparam int unsigned COIN_B = DW - 2;
  localparam int unsigned WAKE_B = DW - 3;

  logic          en_q, wake_q;
  logic [DW-4:0] aux_q;
  logic [DW-1:0] own_q;

  logic full_wr, en_wr, mode_wr, own_wr;

  assign full_wr = we_i & ~bit_i;
  assign en_wr   = we_i & (sel_i == SEL_MODE);
  assign mode_wr = full_wr & (sel_i == SEL_MODE);
  assign own_wr  = full_wr & (sel_i == SEL_OWN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      wake_q <= 1'b0;
      aux_q  <= '0;
      own_q  <= '0;
    end else begin
      if (en_wr) en_q <= wdata_i[EN_B];
      if (mode_wr) begin
        wake_q <= wdata_i[WAKE_B];
        aux_q  <= wdata_i[DW-4:0];
      end
      if (own_wr) own_q <= wdata_i;
    end
  end

  assign en_o       = en_q;
  assign wake_o     = wake_q;
  assign aux_o      = aux_q;
  assign own_o      = own_q;
  assign coin_clr_o = mode_wr & ~wdata_i[COIN_B];
  assign pend_clr_o = full_wr & (sel_i == SEL_STAT) & wdata_i[STAT_PEND_B];
  assign sr_wr_o    = full_wr & (sel_i == SEL_SHIFT);
endmodule

// File: rtl/sam_cmp.sv
`timescale 1ns/1ps
module sam_cmp
  import sam_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic          en_i,
  input  logic          wake_i,
  input  logic          addr_vld_i,
  input  logic [DW-1:0] addr_i,
  input  logic          data_vld_i,
  input  logic [DW-1:0] own_i,
  output sam_ev_t       ev_o
);
  logic [DW-1:0] eq_bit;
  logic          eq, byte_ev;

  for (genvar b = 0; b < DW; b++) begin : g_eq
    assign eq_bit[b] = ~(addr_i[b] ^ own_i[b]);
  end

  assign eq      = &eq_bit;
  assign byte_ev = en_i & (addr_vld_i | data_vld_i);

  always_comb begin
    ev_o.hit  = en_i & addr_vld_i & eq;
    ev_o.miss = en_i & addr_vld_i & ~eq;
    ev_o.fire = wake_i ? ev_o.hit : byte_ev;
  end
endmodule

// File: rtl/sam_flags.sv
`timescale 1ns/1ps
module sam_flags
  import sam_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  sam_ev_t ev_i,
  input  logic    rel_set_i,
  input  logic    coin_clr_i,
  input  logic    pend_clr_i,
  output logic    coin_o,
  output logic    rel_o,
  output logic    irq_o,
  output logic    pend_o
);
  logic coin_q, rel_q, irq_q, pend_q;

  // hardware events win over host clears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coin_q <= 1'b0;
      rel_q  <= 1'b0;
      irq_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (ev_i.hit)        coin_q <= 1'b1;
      else if (ev_i.miss)  coin_q <= 1'b0;
      else if (coin_clr_i) coin_q <= 1'b0;

      if (rel_set_i)      rel_q <= 1'b1;
      else if (ev_i.miss) rel_q <= 1'b0;

      irq_q <= ev_i.fire;
      if (ev_i.fire)       pend_q <= 1'b1;
      else if (pend_clr_i) pend_q <= 1'b0;
    end
  end

  assign coin_o = coin_q;
  assign rel_o  = rel_q;
  assign irq_o  = irq_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/sam_shift.sv
`timescale 1ns/1ps
module sam_shift
  import sam_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          shift_i,
  input  logic          sin_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] sr_o,
  output logic          sout_o
);
  logic [DW-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              sr_q <= '0;
    else if (wr_i)            sr_q <= wdata_i;
    else if (en_i && shift_i) sr_q <= {sr_q[DW-2:0], sin_i};
  end

  assign sr_o   = sr_q;
  assign sout_o = sr_q[DW-1];
endmodule

// File: rtl/slv_addr_match.sv
`timescale 1ns/1ps
module slv_addr_match
  import sam_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_bit_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          addr_vld_i,
  input  logic [DW-1:0] addr_byte_i,
  input  logic          data_vld_i,
  input  logic          bus_rel_i,
  input  logic          shift_i,
  input  logic          sin_i,
  output logic          sout_o,
  output logic          coin_o,
  output logic          rel_o,
  output logic          irq_o,
  output logic          irq_pend_o
);
  localparam int unsigned STAT_PAD = DW - 2;

  logic          en_w, wake_w, coin_clr_w, pend_clr_w, sr_wr_w;
  logic [DW-4:0] aux_w;
  logic [DW-1:0] own_w, sr_w;
  sam_ev_t       ev_w;

  sam_regs #(.DW(DW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .bit_i      (reg_bit_i),
    .sel_i      (reg_sel_i),
    .wdata_i    (reg_wdata_i),
    .en_o       (en_w),
    .wake_o     (wake_w),
    .aux_o      (aux_w),
    .own_o      (own_w),
    .coin_clr_o (coin_clr_w),
    .pend_clr_o (pend_clr_w),
    .sr_wr_o    (sr_wr_w)
  );

  sam_cmp #(.DW(DW)) u_cmp (
    .en_i       (en_w),
    .wake_i     (wake_w),
    .addr_vld_i (addr_vld_i),
    .addr_i     (addr_byte_i),
    .data_vld_i (data_vld_i),
    .own_i      (own_w),
    .ev_o       (ev_w)
  );

  sam_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_i       (ev_w),
    .rel_set_i  (bus_rel_i),
    .coin_clr_i (coin_clr_w),
    .pend_clr_i (pend_clr_w),
    .coin_o     (coin_o),
    .rel_o      (rel_o),
    .irq_o      (irq_o),
    .pend_o     (irq_pend_o)
  );

  sam_shift #(.DW(DW)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_w),
    .shift_i (shift_i),
    .sin_i   (sin_i),
    .wr_i    (sr_wr_w),
    .wdata_i (reg_wdata_i),
    .sr_o    (sr_w),
    .sout_o  (sout_o)
  );

  always_comb begin
    unique case (reg_sel_i)
      SEL_MODE:  reg_rdata_o = {en_w, coin_o, wake_w, aux_w};
      SEL_OWN:   reg_rdata_o = own_w;
      SEL_SHIFT: reg_rdata_o = sr_w;
      default:   reg_rdata_o = {{STAT_PAD{1'b0}}, rel_o, irq_pend_o};
    endcase
  end
endmodule

// File: rtl/sam_chk.sv
`timescale 1ns/1ps
module sam_chk
  import sam_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          wake_i,
  input logic          addr_vld_i,
  input logic [DW-1:0] addr_byte_i,
  input logic          data_vld_i,
  input logic [DW-1:0] own_i,
  input logic          bus_rel_i,
  input logic          we_i,
  input logic          bit_i,
  input logic [1:0]    sel_i,
  input logic [DW-1:0] sr_i,
  input logic          coin_i,
  input logic          rel_i,
  input logic          irq_i,
  input logic          pend_i
);
  a_r2_hit_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && addr_vld_i && (addr_byte_i == own_i) |=> coin_i);

  a_r2_miss_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && addr_vld_i && (addr_byte_i != own_i) |=> !coin_i);

  a_r3_miss_drops_rel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && addr_vld_i && (addr_byte_i != own_i) && !bus_rel_i |=> !rel_i);

  a_r3_rel_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rel_i |=> rel_i);

  a_r4_wake_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i && !(en_i && addr_vld_i && (addr_byte_i == own_i)) |=> !irq_i);

  a_r5_every_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !wake_i && (addr_vld_i || data_vld_i) |=> irq_i);

  a_r6_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !irq_i);

  a_r6_halt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !(we_i && !bit_i && sel_i == SEL_SHIFT) |=> $stable(sr_i));

  a_r9_pend_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> pend_i);
endmodule

bind slv_addr_match sam_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_w),
  .wake_i      (wake_w),
  .addr_vld_i  (addr_vld_i),
  .addr_byte_i (addr_byte_i),
  .data_vld_i  (data_vld_i),
  .own_i       (own_w),
  .bus_rel_i   (bus_rel_i),
  .we_i        (reg_we_i),
  .bit_i       (reg_bit_i),
  .sel_i       (reg_sel_i),
  .sr_i        (sr_w),
  .coin_i      (coin_o),
  .rel_i       (rel_o),
  .irq_i       (irq_o),
  .pend_i      (irq_pend_o)
);

// File: tb/slv_addr_match_test.sv
`timescale 1ns/100ps
module slv_addr_match_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 0, bw = 0, avld = 0, dvld = 0, relin = 0, sh = 0, sin = 0;
  logic [1:0] sel = 0;
  logic [7:0] wd = 0, abyte = 0;
  logic [7:0] rdata;
  logic       sout, coin, rel, irq, pend;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  slv_addr_match uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_bit_i(bw), .reg_sel_i(sel),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .addr_vld_i(avld), .addr_byte_i(abyte),
    .data_vld_i(dvld), .bus_rel_i(relin), .shift_i(sh), .sin_i(sin), .sout_o(sout),
    .coin_o(coin), .rel_o(rel), .irq_o(irq), .irq_pend_o(pend)
  );

  // behavioural reference
  bit       m_en, m_wake, m_coin, m_rel, m_irq, m_pend;
  bit [4:0] m_aux;
  bit [7:0] m_own, m_sr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_wake = 0; m_coin = 0; m_rel = 0; m_irq = 0; m_pend = 0;
      m_aux = 0; m_own = 0; m_sr = 0;
    end else begin
      bit hit, miss, fire, full;
      full = we && !bw;
      hit  = m_en && avld && (abyte == m_own);
      miss = m_en && avld && (abyte != m_own);
      fire = m_wake ? hit : (m_en && (avld || dvld));
      if (hit) m_coin = 1;
      else if (miss) m_coin = 0;
      else if (full && sel == 0 && !wd[6]) m_coin = 0;
      if (relin) m_rel = 1;
      else if (miss) m_rel = 0;
      m_irq = fire;
      if (fire) m_pend = 1;
      else if (full && sel == 3 && wd[0]) m_pend = 0;
      if (full && sel == 2) m_sr = wd;
      else if (m_en && sh) m_sr = {m_sr[6:0], sin};
      if (full && sel == 1) m_own = wd;
      if (full && sel == 0) begin m_wake = wd[5]; m_aux = wd[4:0]; end
      if (we && sel == 0) m_en = wd[7];
    end
  end

  function automatic logic [7:0] m_read(input logic [1:0] s);
    case (s)
      2'd0: return {m_en, m_coin, m_wake, m_aux};
      2'd1: return m_own;
      2'd2: return m_sr;
      default: return {6'b0, m_rel, m_pend};
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #0.5;
    if (rst_n && !done) begin
      chk(coin == m_coin, "R2 coin_o", coin, m_coin);
      chk(rel == m_rel, "R3 rel_o", rel, m_rel);
      chk(irq == m_irq, "R4/R5 irq_o", irq, m_irq);
      chk(pend == m_pend, "R9 irq_pend_o", pend, m_pend);
      chk(sout == m_sr[7], "R7 sout_o", sout, m_sr[7]);
      chk(rdata == m_read(sel), "R6/R8/R10 reg_rdata_o", rdata, m_read(sel));
    end
  end

  task automatic step(input bit w, input bit b, input logic [1:0] s, input logic [7:0] d,
                      input bit av, input logic [7:0] ab, input bit dv, input bit rl,
                      input bit sft, input bit si);
    we = w; bw = b; sel = s; wd = d; avld = av; abyte = ab; dvld = dv;
    relin = rl; sh = sft; sin = si;
    @(negedge clk); #1;
    we = 0; bw = 0; sel = 0; wd = 0; avld = 0; abyte = 0; dvld = 0;
    relin = 0; sh = 0; sin = 0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    step(1, 0, s, d, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    sel = s; #0.2; v = rdata;
  endtask

  logic [7:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd(s[1:0], v); chk(v == 8'h00, "R1 reset register", v, 8'h00);
    end
    chk({coin, rel, irq, pend} == 4'b0, "R1 reset outputs", {4'b0, coin, rel, irq, pend}, 8'h00);

    // R6 halt: plain register, shifts and strobes ignored
    wr(2, 8'hA5);
    rd(2, v); chk(v == 8'hA5, "R6 halt shift reg write", v, 8'hA5);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    rd(2, v); chk(v == 8'hA5, "R6 halt no shift", v, 8'hA5);
    step(0, 0, 0, 0, 1, 8'h00, 1, 0, 0, 0);
    chk(irq == 0 && coin == 0, "R6 halt strobe ignored", {coin, irq}, 0);

    // R10 own address
    wr(1, 8'h5A);
    rd(1, v); chk(v == 8'h5A, "R10 own address", v, 8'h5A);

    // R8 single-bit write touches only enable
    step(1, 1, 0, 8'hFF, 0, 0, 0, 0, 0, 0);
    rd(0, v); chk(v == 8'h80, "R8 bit write only enable", v, 8'h80);
    step(1, 1, 1, 8'h33, 0, 0, 0, 0, 0, 0);
    rd(1, v); chk(v == 8'h5A, "R8 bit write other select ignored", v, 8'h5A);

    // R7 shift while enabled
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    rd(2, v); chk(v == 8'h4B, "R7 shift in", v, 8'h4B);
    chk(sout == 0, "R7 sout msb", sout, 0);
    step(1, 0, 2, 8'hC3, 0, 0, 0, 0, 1, 0);
    rd(2, v); chk(v == 8'hC3, "R7 write beats shift", v, 8'hC3);

    // R5 wake=0: every byte interrupts; R9 clear
    wr(0, 8'h80);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk(irq == 1 && pend == 1, "R5 data byte irq", {irq, pend}, 2'b11);
    @(negedge clk); #1;
    chk(irq == 0, "R9 one-cycle pulse", irq, 0);
    wr(3, 8'h01);
    chk(pend == 0, "R9 pending cleared", pend, 0);

    // R3 / R2 / R5 addresses
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk(rel == 1, "R3 release set", rel, 1);
    step(0, 0, 0, 0, 1, 8'h5A, 0, 0, 0, 0);
    chk(coin == 1 && rel == 1 && irq == 1, "R2 match", {coin, rel, irq}, 3'b111);
    rd(0, v); chk(v[6] == 1, "R2 mode bit 6", v, 8'hC0);
    step(0, 0, 0, 0, 1, 8'h11, 0, 0, 0, 0);
    chk(coin == 0 && rel == 0 && irq == 1, "R3 mismatch clears", {coin, rel, irq}, 3'b001);
    step(0, 0, 0, 0, 1, 8'h11, 0, 1, 0, 0);
    chk(rel == 1, "R3 set wins over clear", rel, 1);

    // R4 wake=1
    wr(3, 8'h01);
    wr(0, 8'hA0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk(irq == 0, "R4 data byte quiet", irq, 0);
    step(0, 0, 0, 0, 1, 8'h12, 0, 0, 0, 0);
    chk(irq == 0 && pend == 0, "R4 mismatch quiet", {irq, pend}, 0);
    step(0, 0, 0, 0, 1, 8'h5A, 0, 0, 0, 0);
    chk(irq == 1, "R4 match interrupts", irq, 1);

    // R11 / R8 coincidence vs host clear
    step(1, 0, 0, 8'hA0, 1, 8'h5A, 0, 0, 0, 0);
    chk(coin == 1, "R11 match beats clear", coin, 1);
    wr(0, 8'hE0);
    chk(coin == 1, "R8 write 1 keeps flag", coin, 1);
    wr(0, 8'hA0);
    chk(coin == 0, "R8 write 0 clears flag", coin, 0);
    wr(0, 8'hE0);
    chk(coin == 0, "R8 write 1 does not set", coin, 0);

    // R9 interrupt beats pending clear
    step(1, 0, 3, 8'h01, 1, 8'h5A, 0, 0, 0, 0);
    chk(pend == 1, "R9 set beats clear", pend, 1);

    // mixed random phase against the model
    for (int i = 0; i < 600; i++) begin
      logic [7:0] r;
      r = $urandom;
      step(r[0] & r[1], r[2] & r[3], 2'($urandom), 8'($urandom),
           r[4], ($urandom % 3 == 0) ? m_own : 8'($urandom), r[5], r[6] & r[7],
           $urandom % 2, $urandom % 2);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule